// File: doc/BRIEF.md
# ADC Sample Conditioning and Register Port

This block sits between a 14-bit converter core and a shared parallel bus. Each raw sample arrives with a valid strobe and an out-of-range indication from the core. The block can add a signed DC correction to the sample, clamps the result to the 14-bit code range, and recodes it as either unsigned binary or two's complement. The conditioned word is stored in a data register together with an out-of-range flag, so the flag always belongs to the word beside it.

Software reaches the block through four registers selected by a 2-bit address: sample data, gain, offset and control. Writes use a strobe and a 16-bit write bus. Reads come out on a three-state bus that is driven only while an active-low output enable is low. The gain code, the reference select and the power-down request are exported as plain outputs for the analogue side.

Top module: `adc_out_cond`

## Requirements
- R1: After reset every register reads 0, and `gain_code`, `ext_ref`, `pwr_down` and `ovr_flag` are 0.
- R2: Address 1 holds the gain code in write bits [2:0], which reads back as {13'b0, code} and drives `gain_code`. Address 2 holds the offset in write bits [7:0], which reads back as {8'b0, offset}.
- R3: Address 3 is the control register. Bit 7 enables offset correction, bit 12 selects the external reference, bit 0 selects two's complement output and bit 1 requests power-down. All other control bits read back as 0.
- R4: A sample is taken on the rising edge where `smp_valid` is high, and the data register shows it from that edge on. With correction off and unsigned format, bits [13:0] of the data register equal the raw sample.
- R5: While control bit 7 is set, the 8-bit offset, read as a two's complement value from -128 to +127, is added to each sample.
- R6: A corrected sum below 0 is stored as 0, and a sum above 16383 is stored as 16383.
- R7: In two's complement format, bit 13 of the unsigned clamped code is inverted, so 0, 8192 and 16383 become -8192, 0 and 8191.
- R8: Data register bit 15 is the out-of-range flag of the stored sample. It is the core's `smp_ovr` input OR'd with a clamp event. Bit 14 reads 0. `ovr_flag` mirrors bit 15.
- R9: Writes to address 0 have no effect on the data register.
- R10: While power-down is set, `smp_valid` is ignored and the data register keeps its last value. `pwr_down` mirrors control bit 1.
- R11: `ext_ref` mirrors control bit 12.
- R12: `rd_bus` carries the addressed register only while `rd_oe_n` is low. Otherwise it is high impedance, and another driver on the bus sets its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Raw sample strobe from the core |
| smp_data | input | 14 | Raw unsigned sample |
| smp_ovr | input | 1 | Core out-of-range indication for this sample |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 data, 1 gain, 2 offset, 3 control) |
| wdata | input | 16 | Write data |
| rd_oe_n | input | 1 | Active-low read output enable |
| rd_bus | inout | 16 | Three-state read data bus |
| gain_code | output | 3 | Gain code for the front end, in 1 dB steps |
| ext_ref | output | 1 | External reference select |
| pwr_down | output | 1 | Power-down request |
| ovr_flag | output | 1 | Out-of-range flag of the stored sample |

## Verification
The situation that is hardest to reach from the ports is a clamp at exactly the code limits. It needs a raw sample within 128 codes of either end together with an offset of the right sign, and it must happen in both output formats. The bench sweeps raw codes with a coarse step and adds every code near both limits. It repeats this for several offsets, including the extremes -128 and +127, with correction both enabled and disabled, and in both formats. A bench-side driver on the shared bus shows that the block releases the bus when its output enable is high.

// File: rtl/adc_out_cond.sv
module adc_out_cond #(
  parameter int DW      = 14,
  parameter int OFW     = 8,
  parameter int GW      = 3,
  parameter int BW      = 16,
  parameter int EN_BIT  = 7,
  parameter int REF_BIT = 12,
  parameter int FMT_BIT = 0,
  parameter int PD_BIT  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          smp_ovr,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [BW-1:0] wdata,
  input  logic          rd_oe_n,
  inout  wire  [BW-1:0] rd_bus,
  output logic [GW-1:0] gain_code,
  output logic          ext_ref,
  output logic          pwr_down,
  output logic          ovr_flag
);
  localparam int SW = DW + 2;
  localparam logic [DW-1:0] CODE_MAX = {DW{1'b1}};
  localparam logic [1:0] A_DATA = 2'd0, A_GAIN = 2'd1, A_OFS = 2'd2, A_CTL = 2'd3;

  logic [DW-1:0]  data_q;
  logic           ovr_q;
  logic [GW-1:0]  gain_q;
  logic [OFW-1:0] ofs_q;
  logic           en_q, ref_q, fmt_q, pd_q;

  wire capture = smp_valid & ~pd_q;

  logic signed [SW-1:0] sum;
  logic                 lo, hi;
  logic [DW-1:0]        clamped, coded;
  logic [BW-1:0]        rd_val, ctl_rd;

  assign sum = $signed({2'b00, smp_data})
             + (en_q ? $signed({{(SW-OFW){ofs_q[OFW-1]}}, ofs_q}) : $signed({SW{1'b0}}));
  assign lo = sum < 0;
  assign hi = sum > $signed({2'b00, CODE_MAX});
  assign clamped = lo ? '0 : (hi ? CODE_MAX : sum[DW-1:0]);
  assign coded = fmt_q ? {~clamped[DW-1], clamped[DW-2:0]} : clamped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else if (capture) begin
      data_q <= coded;
      ovr_q  <= smp_ovr | lo | hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
      ofs_q  <= '0;
      en_q   <= 1'b0;
      ref_q  <= 1'b0;
      fmt_q  <= 1'b0;
      pd_q   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_GAIN: gain_q <= wdata[GW-1:0];
        A_OFS:  ofs_q  <= wdata[OFW-1:0];
        A_CTL: begin
          en_q  <= wdata[EN_BIT];
          ref_q <= wdata[REF_BIT];
          fmt_q <= wdata[FMT_BIT];
          pd_q  <= wdata[PD_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl_rd = '0;
    ctl_rd[EN_BIT]  = en_q;
    ctl_rd[REF_BIT] = ref_q;
    ctl_rd[FMT_BIT] = fmt_q;
    ctl_rd[PD_BIT]  = pd_q;
    case (addr)
      A_DATA:  rd_val = {ovr_q, {(BW-DW-1){1'b0}}, data_q};
      A_GAIN:  rd_val = {{(BW-GW){1'b0}}, gain_q};
      A_OFS:   rd_val = {{(BW-OFW){1'b0}}, ofs_q};
      default: rd_val = ctl_rd;
    endcase
  end

  assign rd_bus    = rd_oe_n ? {BW{1'bz}} : rd_val;
  assign gain_code = gain_q;
  assign ext_ref   = ref_q;
  assign pwr_down  = pd_q;
  assign ovr_flag  = ovr_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (gain_code == '0 && !pwr_down && !ovr_flag)); // R1
  AST_GAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_GAIN) |=> gain_code == $past(wdata[GW-1:0])); // R2
  AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTL) |=> ext_ref == $past(wdata[REF_BIT])); // R11
  AST_PD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTL) |=> pwr_down == $past(wdata[PD_BIT])); // R10
  AST_PD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> ($stable(data_q) && $stable(ovr_flag))); // R10
  AST_DATA_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA && !smp_valid) |=> $stable(data_q)); // R9
  AST_OVR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ovr && !pwr_down) |=> ovr_flag); // R8
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !en_q && !fmt_q) |=> data_q == $past(smp_data)); // R4
endmodule

// File: tb/adc_out_cond_tb.sv
module adc_out_cond_tb;
  logic        clk = 0, rst_n = 0;
  logic        smp_valid = 0, smp_ovr = 0, wr_en = 0, rd_oe_n = 1;
  logic [13:0] smp_data = '0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        tb_drv = 0;
  logic [15:0] tb_pat = '0;
  wire  [15:0] rd_bus;
  logic [2:0]  gain_code;
  logic        ext_ref, pwr_down, ovr_flag;
  int tests = 0, fails = 0;
  bit done = 0;

  assign rd_bus = tb_drv ? tb_pat : 16'bz;

  adc_out_cond u_dut (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ovr(smp_ovr), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_oe_n(rd_oe_n),
    .rd_bus(rd_bus), .gain_code(gain_code), .ext_ref(ext_ref), .pwr_down(pwr_down),
    .ovr_flag(ovr_flag));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd_oe_n = 0;
    #1 v = rd_bus;
    rd_oe_n = 1;
  endtask

  task automatic push(input int raw, input logic ov);
    @(negedge clk); smp_valid = 1; smp_data = 14'(raw); smp_ovr = ov;
    @(negedge clk); smp_valid = 0; smp_ovr = 0;
  endtask

  function automatic logic [15:0] model(int raw, logic ov, logic en, int off, logic fmt);
    int s; logic cl; logic [13:0] d;
    s = raw + (en ? off : 0);
    cl = (s < 0) || (s > 16383);
    if (s < 0) s = 0;
    if (s > 16383) s = 16383;
    d = 14'(s);
    if (fmt) d[13] = ~d[13];
    return {ov | cl, 1'b0, d};
  endfunction

  task automatic one(int raw, logic en, int off, logic fmt);
    logic [15:0] v; logic ov;
    ov = (raw % 5) == 0;
    push(raw, ov);
    rd(2'd0, v);
    chk("R4/R5/R6/R7/R8 sample", v, model(raw, ov, en, off, fmt));
    tests++;
    if (ovr_flag !== v[15]) begin fails++; $display("FAIL R8 ovr_flag actual=%b expected=%b", ovr_flag, v[15]); end
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int offs[5] = '{0, -128, 127, -1, 5};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reset readback", v, 16'h0); end
    chk("R1 outputs", {12'b0, gain_code, ext_ref, pwr_down, ovr_flag}, 16'h0);
    // R2
    wr(2'd1, 16'hfff5); rd(2'd1, v); chk("R2 gain readback", v, 16'h0005);
    chk("R2 gain_code", {13'b0, gain_code}, 16'h0005);
    wr(2'd2, 16'hab80); rd(2'd2, v); chk("R2 offset readback", v, 16'h0080);
    // R3 R11
    wr(2'd3, 16'hffff); rd(2'd3, v); chk("R3 control bits", v, 16'h1083);
    chk("R11 ext_ref", {15'b0, ext_ref}, 16'h1);
    chk("R10 pwr_down port", {15'b0, pwr_down}, 16'h1);
    wr(2'd3, 16'h0000); chk("R11 ext_ref clear", {15'b0, ext_ref}, 16'h0);
    // sweeps
    for (int f = 0; f < 2; f++)
      for (int c = 0; c < 5; c++)
        for (int e = 0; e < 2; e++) begin
          wr(2'd2, 16'(offs[c] & 8'hff));
          wr(2'd3, (e ? 16'h0080 : 16'h0) | 16'(f));
          for (int r = 0; r < 16384; r += 389) one(r, e[0], offs[c], f[0]);
          for (int r = 0; r < 130; r++) one(r, e[0], offs[c], f[0]);
          for (int r = 16254; r < 16384; r++) one(r, e[0], offs[c], f[0]);
        end
    // R9
    wr(2'd3, 16'h0000);
    push(1234, 0);
    wr(2'd0, 16'h3fff); rd(2'd0, v); chk("R9 data write ignored", v, 16'd1234);
    // R10
    wr(2'd3, 16'h0002);
    push(777, 1); rd(2'd0, v); chk("R10 power-down hold", v, 16'd1234);
    wr(2'd3, 16'h0000);
    push(777, 1); rd(2'd0, v); chk("R10 resume", v, 16'h8000 | 16'd777);
    // R12
    @(negedge clk); addr = 2'd1; rd_oe_n = 1; tb_drv = 1; tb_pat = 16'h5a3c;
    #1 chk("R12 released bus", rd_bus, 16'h5a3c);
    tb_drv = 0; tb_pat = 16'h0;
    rd(2'd1, v); chk("R12 driven bus", v, 16'h0005);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule